// File: doc/BRIEF.md
# FIFO Retransmit Controller

This block adds a replay function to a FIFO with a single address space. A request to replay makes reading start again at memory address zero, so words that were already consumed come out a second time. The controller runs on the read clock. On each edge it samples an active-low replay strobe and the active-low read and write enables. From these it keeps a count of words written and a count of words read since the last reset.

A request is accepted only when two things hold. The enables must be quiet around the strobe, and both word counts must lie inside a window bounded by the effective depth. An accepted request starts a setup phase of fixed length. At its start the controller emits a one-cycle request that moves the FIFO's read pointer back to zero. In standard timing mode it also holds the empty flag low for as long as setup lasts. When setup ends, normal reads resume and the FIFO rebuilds its empty flag from its own pointers.

A request that breaks the rules sets a sticky error flag and leaves the read pointer where it was. In first-word-fall-through mode the effective depth is one word larger, and the empty flag is never overridden.

Top module: `rtx_ctrl`

## Requirements
- R1: A replay request is the first read-clock edge at which `rt_n` is sampled low after being sampled high (high after reset). Holding `rt_n` low for more edges produces no further request.
- R2: A request is legal only if `ren_n` and `wen_n` are both sampled high at the request edge and at the edge before it. Otherwise it is rejected.
- R3: A request is legal only if the number of words written and the number of words read since the last reset each lie between 2 and E-2 inclusive. E is the effective depth, and both counts saturate at E.
- R4: After a legal request edge, `rptr_rst` is high for exactly one cycle.
- R5: After a legal request edge, `setup_busy` is high for exactly SETUP_CYC cycles, then low.
- R6: In standard mode (FWFT=0), `ef_low` is high exactly while `setup_busy` is high. In FWFT mode it is always low.
- R7: With FWFT=1 the effective depth E is DEPTH+1. With FWFT=0 it is DEPTH.
- R8: A rejected request raises `rt_err`, which stays high until master reset. A rejected request produces no `rptr_rst` pulse and no setup.
- R9: A partial reset (`prst_n` low on an edge) clears both word counts but leaves `rt_err` unchanged. A master reset (`rst_n` low) clears the counts and `rt_err`.
- R10: A request that arrives while `setup_busy` is high is ignored. It causes no new setup, no `rptr_rst` pulse and no error.
- R11: After setup completes, the next FIFO read returns the first word written since reset.
- R12: While master reset is asserted and right after it, `rptr_rst`, `setup_busy`, `ef_low` and `rt_err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| rt_n | input | 1 | Replay strobe, active low |
| ren_n | input | 1 | Read enable, active low |
| wen_n | input | 1 | Write enable, active low |
| rptr_rst | output | 1 | One-cycle request to return the read pointer to address zero |
| ef_low | output | 1 | Forces the empty flag low during setup (standard mode) |
| setup_busy | output | 1 | Setup phase in progress |
| rt_err | output | 1 | Sticky flag for a rejected replay request |

## Verification
The bench sweeps every combination of write and read counts from 0 to DEPTH+1 on a standard instance and an FWFT instance side by side. An off-by-one in either window bound, or an effective depth that ignores the mode, shows up as an accept or reject on the wrong count pair. Directed cases cover the following:
- An enable that is active on the request edge or the edge before it. A design that checks only one of these edges accepts a request it should refuse.
- A strobe held low across several edges. A level-sensitive design restarts setup on every edge.
- A second falling strobe on the last setup cycle. This would wrongly restart setup.
- A partial reset. A design that does not clear the counts on it accepts a replay it should refuse, and one that clears too much loses the error flag.
- A read after setup. It must return the first word written; a design that never moves the pointer fails this.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

   typedef enum logic [0:0] {
      RTX_IDLE  = 1'b0,
      RTX_SETUP = 1'b1
   } rtx_state_e;

   // inclusive range test used for the word-count window
   function automatic logic in_window(input int unsigned cnt,
                                      input int unsigned lo,
                                      input int unsigned hi);
      return (cnt >= lo) && (cnt <= hi);
   endfunction

endpackage

// File: rtl/rtx_word_cnt.sv
module rtx_word_cnt #(
   parameter int unsigned LIMIT = 16,
   localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rtx_word_cnt: LIMIT must be at least 1");
   end

   localparam logic [CW-1:0] CMAX = CW'(LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (inc && (cnt != CMAX)) begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rtx_req_detect.sv
module rtx_req_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic rt_n,
   input  logic ren_n,
   input  logic wen_n,
   output logic req,
   output logic en_ok
);

   logic rt_q;
   logic ren_q;
   logic wen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rt_q  <= 1'b1;
         ren_q <= 1'b1;
         wen_q <= 1'b1;
      end else begin
         rt_q  <= rt_n;
         ren_q <= ren_n;
         wen_q <= wen_n;
      end
   end

   // request on the first low sample following a high one
   assign req   = !rt_n && rt_q;
   // enables idle on this edge and the edge before it
   assign en_ok = ren_n && wen_n && ren_q && wen_q;

endmodule

// File: rtl/rtx_setup_seq.sv
module rtx_setup_seq
   import rtx_pkg::*;
#(
   parameter int unsigned SETUP_CYC = 2,
   localparam int unsigned SW       = $clog2(SETUP_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   output logic busy,
   output logic ptr_rst
);

   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("rtx_setup_seq: SETUP_CYC must be at least 1");
   end

   rtx_state_e    state;
   logic [SW-1:0] left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RTX_IDLE;
         left    <= '0;
         ptr_rst <= 1'b0;
      end else if (clr) begin
         state   <= RTX_IDLE;
         left    <= '0;
         ptr_rst <= 1'b0;
      end else begin
         ptr_rst <= 1'b0;
         case (state)
            RTX_IDLE: begin
               if (start) begin
                  state   <= RTX_SETUP;
                  left    <= SW'(SETUP_CYC - 1);
                  ptr_rst <= 1'b1;
               end
            end
            RTX_SETUP: begin
               if (left == '0) begin
                  state <= RTX_IDLE;
               end else begin
                  left <= left - 1'b1;
               end
            end
            default: state <= RTX_IDLE;
         endcase
      end
   end

   assign busy = (state == RTX_SETUP);

endmodule

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
   import rtx_pkg::*;
#(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned SETUP_CYC = 2,
   parameter bit          FWFT      = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prst_n,
   input  logic rt_n,
   input  logic ren_n,
   input  logic wen_n,
   output logic rptr_rst,
   output logic ef_low,
   output logic setup_busy,
   output logic rt_err
);

   localparam int unsigned D_EFF  = DEPTH + (FWFT ? 1 : 0);
   localparam int unsigned WIN_LO = 2;
   localparam int unsigned WIN_HI = D_EFF - 2;
   localparam int unsigned CW     = $clog2(D_EFF + 1);

   if (DEPTH < 4) begin : g_bad_depth
      $error("rtx_ctrl: DEPTH must be at least 4");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("rtx_ctrl: SETUP_CYC must be at least 1");
   end

   logic [CW-1:0] wr_cnt;
   logic [CW-1:0] rd_cnt;
   logic          rt_req;
   logic          en_ok;
   logic          win_ok;
   logic          accept;
   logic          legal;
   logic          start;
   logic          busy;

   rtx_word_cnt #(.LIMIT(D_EFF)) u_wr_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!prst_n),
      .inc   (!wen_n),
      .cnt   (wr_cnt)
   );

   rtx_word_cnt #(.LIMIT(D_EFF)) u_rd_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!prst_n),
      .inc   (!ren_n),
      .cnt   (rd_cnt)
   );

   rtx_req_detect u_req (
      .clk   (clk),
      .rst_n (rst_n),
      .rt_n  (rt_n),
      .ren_n (ren_n),
      .wen_n (wen_n),
      .req   (rt_req),
      .en_ok (en_ok)
   );

   assign win_ok = in_window(int'(wr_cnt), WIN_LO, WIN_HI)
                && in_window(int'(rd_cnt), WIN_LO, WIN_HI);
   assign accept = rt_req && !busy && prst_n;
   assign legal  = en_ok && win_ok;
   assign start  = accept && legal;

   rtx_setup_seq #(.SETUP_CYC(SETUP_CYC)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!prst_n),
      .start   (start),
      .busy    (busy),
      .ptr_rst (rptr_rst)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rt_err <= 1'b0;
      end else if (accept && !legal) begin
         rt_err <= 1'b1;
      end
   end

   assign setup_busy = busy;

   if (FWFT) begin : g_ef_fwft
      assign ef_low = 1'b0;
   end else begin : g_ef_std
      assign ef_low = busy;
   end

endmodule

// File: rtl/rtx_ctrl_chk.sv
module rtx_ctrl_chk #(
   parameter int unsigned SETUP_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic prst_n,
   input logic rt_n,
   input logic ren_n,
   input logic wen_n,
   input logic rptr_rst,
   input logic ef_low,
   input logic setup_busy,
   input logic rt_err
);

   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run <= 0;
      end else if (setup_busy) begin
         run <= run + 1;
      end else begin
         run <= 0;
      end
   end

   AST_PTR_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_rst |=> !rptr_rst); // R4

   AST_PTR_RST_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_rst |-> setup_busy); // R5

   AST_SETUP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(setup_busy) |-> !$past(rt_n)); // R1

   AST_ENABLES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      rptr_rst |-> ($past(ren_n) && $past(wen_n))); // R2

   AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      setup_busy |-> (run < SETUP_CYC)); // R5

   AST_BUSY_FULL_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(setup_busy) && $past(prst_n)) |-> (run == SETUP_CYC)); // R5

   AST_EF_ONLY_IN_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ef_low |-> setup_busy); // R6

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      rt_err |=> rt_err); // R8

   AST_ERR_NO_PTR_RST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rt_err) |-> !rptr_rst); // R8

endmodule

bind rtx_ctrl rtx_ctrl_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .prst_n     (prst_n),
   .rt_n       (rt_n),
   .ren_n      (ren_n),
   .wen_n      (wen_n),
   .rptr_rst   (rptr_rst),
   .ef_low     (ef_low),
   .setup_busy (setup_busy),
   .rt_err     (rt_err)
);

// File: tb/tb_rtx_ctrl.sv
`timescale 1ns/1ps
module tb_rtx_ctrl;

   localparam int DEPTH = 8;
   localparam int SCYC  = 2;
   localparam int E_STD = DEPTH;
   localparam int E_FW  = DEPTH + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic prst_n = 1'b1;
   logic rt_n = 1'b1;
   logic ren_n = 1'b1;
   logic wen_n = 1'b1;
   logic [7:0] wdata = 8'h00;

   logic rptr_rst, ef_low, setup_busy, rt_err;
   logic f_rptr_rst, f_ef_low, f_setup_busy, f_rt_err;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   rtx_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SCYC), .FWFT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .rt_n(rt_n),
      .ren_n(ren_n), .wen_n(wen_n), .rptr_rst(rptr_rst),
      .ef_low(ef_low), .setup_busy(setup_busy), .rt_err(rt_err));

   rtx_ctrl #(.DEPTH(DEPTH), .SETUP_CYC(SCYC), .FWFT(1'b1)) dut_fw (
      .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .rt_n(rt_n),
      .ren_n(ren_n), .wen_n(wen_n), .rptr_rst(f_rptr_rst),
      .ef_low(f_ef_low), .setup_busy(f_setup_busy), .rt_err(f_rt_err));

   // small behavioural FIFO driven by the standard instance
   logic [7:0] mem [16];
   logic [3:0] wp, rp;
   logic [7:0] q;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp <= '0;
         rp <= '0;
         q  <= '0;
      end else begin
         if (!wen_n) begin
            mem[wp] <= wdata;
            wp <= wp + 1'b1;
         end
         if (rptr_rst) begin
            rp <= '0;
         end else if (!ren_n) begin
            q  <= mem[rp];
            rp <= rp + 1'b1;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic mreset();
      rst_n = 1'b0; rt_n = 1'b1; ren_n = 1'b1; wen_n = 1'b1; prst_n = 1'b1;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic fill(input int nw, input int nr);
      for (int i = 0; i < nw; i++) begin
         wen_n = 1'b0; wdata = 8'(8'hA0 + i);
         tick();
      end
      wen_n = 1'b1;
      for (int i = 0; i < nr; i++) begin
         ren_n = 1'b0;
         tick();
      end
      ren_n = 1'b1;
   endtask

   function automatic bit win(input int n, input int e);
      return (n >= 2) && (n <= e - 2);
   endfunction

   task automatic trial(input int nw, input int nr);
      bit ls, lf;
      ls = win(nw, E_STD) && win(nr, E_STD);
      lf = win(nw, E_FW) && win(nr, E_FW);
      mreset();
      fill(nw, nr);
      tick();
      rt_n = 1'b0;
      tick();
      chk("R3 std accept", int'(rptr_rst), int'(ls));
      chk("R4 std ptr pulse", int'(rptr_rst), int'(ls));
      chk("R5 std busy", int'(setup_busy), int'(ls));
      chk("R6 std ef", int'(ef_low), int'(ls));
      chk("R8 std err", int'(rt_err), int'(!ls));
      chk("R7 fwft accept", int'(f_rptr_rst), int'(lf));
      chk("R7 fwft err", int'(f_rt_err), int'(!lf));
      chk("R6 fwft ef", int'(f_ef_low), 0);
      rt_n = 1'b1;
      tick();
      chk("R4 std pulse ends", int'(rptr_rst), 0);
      chk("R5 std busy 2nd", int'(setup_busy), int'(ls));
      chk("R5 fwft busy 2nd", int'(f_setup_busy), int'(lf));
      tick();
      chk("R5 std busy done", int'(setup_busy), 0);
      chk("R6 std ef done", int'(ef_low), 0);
      if (ls) begin
         ren_n = 1'b0;
         tick();
         ren_n = 1'b1;
         chk("R11 replay first word", int'(q), 8'hA0);
      end
      tick();
      chk("R8 std err sticky", int'(rt_err), int'(!ls));
   endtask

   initial begin
      #400000;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int pulses;
      rst_n = 1'b0;
      tick();
      chk("R12 reset ptr", int'(rptr_rst), 0);
      chk("R12 reset busy", int'(setup_busy), 0);
      chk("R12 reset ef", int'(ef_low), 0);
      chk("R12 reset err", int'(rt_err), 0);
      mreset();
      chk("R12 after reset err", int'(rt_err | f_rt_err), 0);

      // R3 R7 sweep of write/read counts
      for (int nw = 0; nw <= DEPTH + 1; nw++) begin
         for (int nr = 0; nr <= DEPTH + 1; nr++) begin
            trial(nw, nr);
         end
      end

      // R2 read on the edge before the strobe
      mreset(); fill(4, 3);
      ren_n = 1'b0; tick();
      ren_n = 1'b1; rt_n = 1'b0; tick();
      chk("R2 prior read rejects", int'(rt_err), 1);
      chk("R2 prior read no ptr", int'(rptr_rst), 0);
      rt_n = 1'b1; tick();

      // R2 write on the strobe edge
      mreset(); fill(4, 3); tick();
      wen_n = 1'b0; rt_n = 1'b0; tick();
      wen_n = 1'b1;
      chk("R2 same edge write rejects", int'(rt_err), 1);
      chk("R2 same edge no busy", int'(setup_busy), 0);
      rt_n = 1'b1; tick();

      // R1 strobe held low
      mreset(); fill(4, 3); tick();
      rt_n = 1'b0; pulses = 0;
      for (int i = 0; i < 6; i++) begin
         tick();
         pulses += int'(rptr_rst);
      end
      chk("R1 single request", pulses, 1);
      chk("R1 busy ends", int'(setup_busy), 0);
      chk("R1 no error", int'(rt_err), 0);
      rt_n = 1'b1; tick();

      // R10 request on the last setup cycle
      mreset(); fill(4, 3); tick();
      rt_n = 1'b0; tick();
      rt_n = 1'b1; tick();
      rt_n = 1'b0; tick();
      chk("R10 ignored busy", int'(setup_busy), 0);
      chk("R10 ignored ptr", int'(rptr_rst), 0);
      chk("R10 ignored err", int'(rt_err), 0);
      rt_n = 1'b1; tick();

      // R9 partial reset clears counts, keeps error
      mreset(); fill(4, 3); tick();
      prst_n = 1'b0; tick();
      prst_n = 1'b1; tick();
      rt_n = 1'b0; tick();
      chk("R9 counts cleared std", int'(rt_err), 1);
      chk("R9 counts cleared fwft", int'(f_rt_err), 1);
      rt_n = 1'b1;
      prst_n = 1'b0; tick();
      prst_n = 1'b1; tick();
      chk("R9 partial keeps err", int'(rt_err), 1);
      mreset();
      chk("R9 master clears err", int'(rt_err), 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule